// File: doc/BRIEF.md
# Bayer Sensor Parallel Pixel Receiver

This block receives the 12-bit parallel pixel stream of a progressive-scan colour image sensor. The stream comes with a frame qualifier, a line qualifier and the sensor's pixel clock. The block samples the stream on the falling clock edge and tracks the row and column of every accepted pixel. It tags each pixel with one of four colour-filter channels, and the two green sites are kept apart. The pixels leave on a valid/ready stream that also carries a start-of-frame flag, an end-of-line flag and the channel code.

The frame qualifier stays high through horizontal blanking and drops only between frames. The line qualifier marks active pixels only. The end of a line is therefore seen at the falling edge of the line qualifier, and the end of a frame at the falling edge of the frame qualifier. At the end of each frame the block reports the number of lines and the pixels in the latest line. It flags a frame whose geometry does not match the configured width and height; the default image is 2592 by 1944. A small buffer absorbs short stalls of the consumer. A sticky flag records any pixel that had to be dropped.

Top module: `bayer_rx`

## Requirements
- R1: `sen_data` (bit 11 MSB, bit 0 LSB), `sen_fv` and `sen_lv` are sampled on the falling edge of `clk`. Each accepted pixel appears unchanged on `out_data`, in arrival order.
- R2: A pixel is accepted only in a sample where both `sen_fv` and `sen_lv` are high. Data during blanking is ignored, and so is `sen_lv` while `sen_fv` is low.
- R3: `out_chan` is {row parity, column parity}: 00 Gr (even row, even column), 01 R (even row, odd column), 10 B (odd row, even column), 11 Gb (odd row, odd column). The row is 0 after a rising edge of the frame qualifier, and the column is 0 at the start of every line.
- R4: `out_sof` is 1 on the first pixel of each frame and 0 on every other pixel; that pixel always carries channel Gr.
- R5: `out_eol` is 1 on the last pixel of every line, decided by the falling line qualifier, and 0 elsewhere.
- R6: On each falling edge of the frame qualifier, `frame_done` pulses for one cycle. `line_count` then holds the number of lines in that frame, and `line_pixels` holds the pixel count of the most recent line.
- R7: `size_err` is set at the end of a frame if the line count differs from `cfg_height` or any line's length differs from `cfg_width`. It is cleared at the end of a frame that matches, and it changes only in a cycle where `frame_done` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the output fields stay stable. Up to FIFO_DEPTH pixels are held without loss.
- R9: `overflow` is set when an accepted pixel finds the buffer full with no pop in the same cycle. It stays set until reset.
- R10: After reset, `out_valid`, `frame_done`, `size_err` and `overflow` are 0, and `line_count` and `line_pixels` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sen_fv | input | 1 | Frame qualifier from the sensor |
| sen_lv | input | 1 | Line qualifier from the sensor |
| sen_data | input | 12 | Pixel sample |
| cfg_width | input | COL_W | Expected pixels per line |
| cfg_height | input | ROW_W | Expected lines per frame |
| out_valid | output | 1 | Output pixel available |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_data | output | 12 | Output pixel value |
| out_chan | output | 2 | Colour channel code |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of line |
| line_count | output | ROW_W | Lines in the last finished frame |
| line_pixels | output | COL_W | Pixels in the most recent line |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| size_err | output | 1 | Last frame did not match the configured size |
| overflow | output | 1 | Sticky pixel-drop flag |

## Verification
The bench builds the block with its default parameters: 12-bit column counters, 11-bit row counters and a four-entry buffer. It then programs a tiny 8-by-4 geometry through the configuration ports, so every line end, frame end and parity corner is reached within a few hundred cycles. With a four-entry buffer, a 2-by-2 frame held back by the consumer fills the buffer exactly without loss. An 8-pixel line under the same stall overruns it and raises the drop flag.

// File: rtl/bayer_rx_pkg.sv
// Shared types for the Bayer pixel receiver.
// Assumes a fixed 12-bit sample width from the sensor.
package bayer_rx_pkg;
    localparam int PIX_W = 12;

    typedef enum logic [1:0] {
        CH_GR = 2'b00,
        CH_R  = 2'b01,
        CH_B  = 2'b10,
        CH_GB = 2'b11
    } chan_t;

    typedef struct packed {
        logic [PIX_W-1:0] data;
        chan_t            chan;
        logic             sof;
        logic             eol;
    } pix_t;
endpackage

// File: rtl/bayer_rx_capture.sv
// Input capture: registers the sensor bus on the falling clock edge,
// which is where the sensor guarantees setup and hold.
// Assumes the downstream logic runs on the rising edge of the same clock.
module bayer_rx_capture
    import bayer_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fv_in,
    input  logic             lv_in,
    input  logic [PIX_W-1:0] data_in,
    output logic             fv_s,
    output logic             lv_s,
    output logic [PIX_W-1:0] data_s
);
    // Falling-edge sample of qualifiers and data.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            fv_s   <= 1'b0;
            lv_s   <= 1'b0;
            data_s <= '0;
        end else begin
            fv_s   <= fv_in;
            lv_s   <= lv_in;
            data_s <= data_in;
        end
    end
endmodule

// File: rtl/bayer_rx_position.sv
// Position tracker: counts rows and columns, tags Bayer channel, holds one
// pixel back so the end-of-line flag can be set when the line qualifier
// falls, and checks frame geometry at each frame end.
// Assumes samples are stable from the preceding falling edge.
module bayer_rx_position
    import bayer_rx_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fv_s,
    input  logic             lv_s,
    input  logic [PIX_W-1:0] data_s,
    input  logic [COL_W-1:0] cfg_width,
    input  logic [ROW_W-1:0] cfg_height,
    output logic             push,
    output pix_t             push_pix,
    output logic [ROW_W-1:0] line_count,
    output logic [COL_W-1:0] line_pixels,
    output logic             frame_done,
    output logic             size_err
);
    logic             fv_p, act_p, sof_pend, err_acc, pend_v;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    pix_t             pend;

    logic             take, fv_rise, fv_fall, line_end, err_next;
    logic [ROW_W-1:0] row_eff, row_next;
    logic [COL_W-1:0] col_eff;

    // Edge detection, effective position and hand-off of the held pixel.
    always_comb begin
        take     = fv_s & lv_s;
        fv_rise  = fv_s & ~fv_p;
        fv_fall  = ~fv_s & fv_p;
        line_end = act_p & ~take;
        row_eff  = fv_rise ? '0 : row;
        col_eff  = fv_rise ? '0 : col;
        row_next = line_end ? row + 1'b1 : row;
        err_next = err_acc | (line_end & (col != cfg_width));
        push     = pend_v & (take | line_end);
        push_pix = pend;
        push_pix.eol = line_end;
    end

    // Counters, pixel hold stage and end-of-frame reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fv_p        <= 1'b0;
            act_p       <= 1'b0;
            sof_pend    <= 1'b0;
            err_acc     <= 1'b0;
            pend_v      <= 1'b0;
            pend        <= '0;
            row         <= '0;
            col         <= '0;
            line_count  <= '0;
            line_pixels <= '0;
            frame_done  <= 1'b0;
            size_err    <= 1'b0;
        end else begin
            fv_p       <= fv_s;
            act_p      <= take;
            frame_done <= fv_fall;
            if (fv_rise) begin
                row      <= '0;
                col      <= '0;
                err_acc  <= 1'b0;
                sof_pend <= 1'b1;
            end
            if (take) begin
                col       <= col_eff + 1'b1;
                pend.data <= data_s;
                pend.chan <= chan_t'({row_eff[0], col_eff[0]});
                pend.sof  <= sof_pend | fv_rise;
                pend.eol  <= 1'b0;
                pend_v    <= 1'b1;
                sof_pend  <= 1'b0;
            end else if (line_end) begin
                pend_v      <= 1'b0;
                row         <= row_next;
                col         <= '0;
                line_pixels <= col;
                err_acc     <= err_next;
            end
            if (fv_fall) begin
                line_count <= row_next;
                size_err   <= err_next | (row_next != cfg_height);
            end
        end
    end
endmodule

// File: rtl/bayer_rx_fifo.sv
// Output buffer: a small circular FIFO for tagged pixels with a sticky
// overflow flag. Assumes a push into a full buffer is dropped unless a
// pop frees a slot in the same cycle.
module bayer_rx_fifo
    import bayer_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  pix_t din,
    input  logic pop,
    output pix_t dout,
    output logic empty,
    output logic overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    pix_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    // Occupancy decode and accepted operations.
    always_comb begin
        full    = (cnt == FULL_CNT);
        empty   = (cnt == '0);
        do_pop  = pop & ~empty;
        do_push = push & (~full | do_pop);
        dout    = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer, count and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (push & ~do_push) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/bayer_rx.sv
// Top of the Bayer pixel receiver: falling-edge capture, position and
// channel tagging, geometry check, buffered valid/ready output.
// Assumes clk is the sensor pixel clock and reset is synchronous.
module bayer_rx
    import bayer_rx_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int ROW_W      = 11,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sen_fv,
    input  logic             sen_lv,
    input  logic [11:0]      sen_data,
    input  logic [COL_W-1:0] cfg_width,
    input  logic [ROW_W-1:0] cfg_height,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [11:0]      out_data,
    output logic [1:0]       out_chan,
    output logic             out_sof,
    output logic             out_eol,
    output logic [ROW_W-1:0] line_count,
    output logic [COL_W-1:0] line_pixels,
    output logic             frame_done,
    output logic             size_err,
    output logic             overflow
);
    logic             fv_s, lv_s, push, empty;
    logic [PIX_W-1:0] data_s;
    pix_t             push_pix, head;

    bayer_rx_capture u_cap (
        .clk(clk), .rst_n(rst_n),
        .fv_in(sen_fv), .lv_in(sen_lv), .data_in(sen_data),
        .fv_s(fv_s), .lv_s(lv_s), .data_s(data_s)
    );

    bayer_rx_position #(.COL_W(COL_W), .ROW_W(ROW_W)) u_pos (
        .clk(clk), .rst_n(rst_n),
        .fv_s(fv_s), .lv_s(lv_s), .data_s(data_s),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .push(push), .push_pix(push_pix),
        .line_count(line_count), .line_pixels(line_pixels),
        .frame_done(frame_done), .size_err(size_err)
    );

    bayer_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .din(push_pix),
        .pop(out_ready), .dout(head),
        .empty(empty), .overflow(overflow)
    );

    // Output stream fields from the buffer head.
    always_comb begin
        out_valid = ~empty;
        out_data  = head.data;
        out_chan  = head.chan;
        out_sof   = head.sof;
        out_eol   = head.eol;
    end
endmodule

// File: rtl/bayer_rx_chk.sv
// Property checker for the Bayer pixel receiver, bound to every instance.
module bayer_rx_chk #(
    parameter int COL_W = 12,
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [11:0]      out_data,
    input logic [1:0]       out_chan,
    input logic             out_sof,
    input logic             out_eol,
    input logic [ROW_W-1:0] line_count,
    input logic             frame_done,
    input logic             size_err,
    input logic             overflow
);
    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
            && $stable(out_chan) && $stable(out_sof) && $stable(out_eol));

    // R4
    sof_is_green_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof |-> out_chan == 2'b00);

    // R7
    size_err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(size_err) |-> frame_done);

    // R6
    count_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_count) |-> frame_done);

    // R6
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind bayer_rx bayer_rx_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_bayer_rx.sv
module tb_bayer_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sen_fv = 1'b0, sen_lv = 1'b0;
    logic [11:0] sen_data = '0;
    logic [11:0] cfg_width = 12'd8;
    logic [10:0] cfg_height = 11'd4;
    logic        out_ready = 1'b1;
    logic        out_valid, out_sof, out_eol, frame_done, size_err, overflow;
    logic [11:0] out_data, line_pixels;
    logic [1:0]  out_chan;
    logic [10:0] line_count;

    int n_checks = 0, n_fail = 0, n_rec = 0, n_done = 0;
    bit finished = 0;
    logic [11:0] rec_data [64];
    logic [1:0]  rec_chan [64];
    logic        rec_sof  [64];
    logic        rec_eol  [64];

    bayer_rx dut (.*);

    always #10 clk = ~clk;

    // Monitor: records every transfer and every end-of-frame pulse.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && n_rec < 64) begin
            rec_data[n_rec] = out_data;
            rec_chan[n_rec] = out_chan;
            rec_sof[n_rec]  = out_sof;
            rec_eol[n_rec]  = out_eol;
            n_rec++;
        end
        if (rst_n && frame_done) n_done++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Drives one frame; line bad_row carries bad_w pixels instead of w.
    task automatic send_frame(input int w, input int h, input int bad_row,
                              input int bad_w, input logic [11:0] seed);
        tick(); sen_fv = 1'b1; sen_data = 12'hFFF;
        tick(2);
        for (int r = 0; r < h; r++) begin
            int wl = (r == bad_row) ? bad_w : w;
            for (int c = 0; c < wl; c++) begin
                sen_lv = 1'b1;
                sen_data = seed + 12'(r * 32 + c);
                tick();
            end
            sen_lv = 1'b0; sen_data = 12'h5A5;
            tick(3);
        end
        sen_fv = 1'b0;
        tick(8);
    endtask

    // Compares the recorded stream against the expected frame.
    task automatic check_stream(input int w, input int h, input int bad_row,
                                input int bad_w, input logic [11:0] seed);
        int i = 0, bad_d = 0, bad_c = 0, bad_s = 0, bad_e = 0;
        int ad = 0, ed = 0, ac = 0, ec = 0, as_ = 0, es = 0, ae = 0, ee = 0;
        for (int r = 0; r < h; r++) begin
            int wl = (r == bad_row) ? bad_w : w;
            for (int c = 0; c < wl; c++) begin
                logic [11:0] xd = seed + 12'(r * 32 + c);
                logic [1:0]  xc = {r[0], c[0]};
                logic        xs = (i == 0);
                logic        xe = (c == wl - 1);
                if (i < n_rec) begin
                    if (rec_data[i] !== xd && !bad_d) begin bad_d = 1; ad = rec_data[i]; ed = xd; end
                    if (rec_chan[i] !== xc && !bad_c) begin bad_c = 1; ac = rec_chan[i]; ec = xc; end
                    if (rec_sof[i] !== xs && !bad_s) begin bad_s = 1; as_ = rec_sof[i]; es = xs; end
                    if (rec_eol[i] !== xe && !bad_e) begin bad_e = 1; ae = rec_eol[i]; ee = xe; end
                end
                i++;
            end
        end
        check(n_rec == i, "R1/R2 pixel count", n_rec, i);
        check(!bad_d, "R1 data", ad, ed);
        check(!bad_c, "R3 channel", ac, ec);
        check(!bad_s, "R4 sof", as_, es);
        check(!bad_e, "R5 eol", ae, ee);
    endtask

    task automatic t_reset();
        check(out_valid == 0, "R10 out_valid", out_valid, 0);
        check(size_err == 0 && frame_done == 0, "R10 flags", size_err, 0);
        check(overflow == 0, "R10 overflow", overflow, 0);
        check(line_count == 0 && line_pixels == 0, "R10 counts", line_count, 0);
    endtask

    task automatic t_nominal();
        int d0 = n_done;
        n_rec = 0;
        send_frame(8, 4, -1, 0, 12'hA00);
        check_stream(8, 4, -1, 0, 12'hA00);
        check(n_done == d0 + 1, "R6 frame_done pulses", n_done - d0, 1);
        check(line_count == 4, "R6 line_count", line_count, 4);
        check(line_pixels == 8, "R6 line_pixels", line_pixels, 8);
        check(size_err == 0, "R7 matching frame", size_err, 0);
    endtask

    task automatic t_short_height();
        n_rec = 0;
        send_frame(8, 3, -1, 0, 12'h300);
        check_stream(8, 3, -1, 0, 12'h300);
        check(line_count == 3, "R6 line_count short", line_count, 3);
        check(size_err == 1, "R7 height mismatch", size_err, 1);
    endtask

    task automatic t_short_line();
        n_rec = 0;
        send_frame(8, 4, 1, 5, 12'h7F0);
        check_stream(8, 4, 1, 5, 12'h7F0);
        check(size_err == 1, "R7 line length mismatch", size_err, 1);
        n_rec = 0;
        send_frame(8, 4, -1, 0, 12'h010);
        check(size_err == 0, "R7 cleared by good frame", size_err, 0);
    endtask

    task automatic t_stray_lv();
        n_rec = 0;
        sen_lv = 1'b1; sen_data = 12'h123;
        tick(4);
        sen_lv = 1'b0;
        tick(6);
        check(n_rec == 0, "R2 lv without fv ignored", n_rec, 0);
        check(out_valid == 0, "R2 no output", out_valid, 0);
    endtask

    task automatic t_stall();
        n_rec = 0;
        cfg_width = 12'd2; cfg_height = 11'd2;
        out_ready = 1'b0;
        send_frame(2, 2, -1, 0, 12'hC40);
        check(out_valid == 1, "R8 valid held under stall", out_valid, 1);
        check(overflow == 0, "R8 depth fits without loss", overflow, 0);
        out_ready = 1'b1;
        tick(8);
        check_stream(2, 2, -1, 0, 12'hC40);
    endtask

    task automatic t_overflow();
        n_rec = 0;
        cfg_width = 12'd8; cfg_height = 11'd1;
        out_ready = 1'b0;
        send_frame(8, 1, -1, 0, 12'h000);
        check(overflow == 1, "R9 overflow set", overflow, 1);
        out_ready = 1'b1;
        tick(10);
        check(n_rec == 4, "R9 buffer held depth", n_rec, 4);
        check(overflow == 1, "R9 overflow sticky", overflow, 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(2);
        t_nominal();
        t_short_height();
        t_short_line();
        t_stray_lv();
        t_stall();
        t_overflow();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule